// File: doc/BRIEF.md
# Word DMA channel engine

This block is one DMA channel. It copies 32-bit words from a source address to a destination address, or writes one fixed pattern to the destination without reading memory. Software sets up the channel through a small write-only register file: working addresses, a total word count, a pacing value, a fill word and a control word. It then starts the channel by writing the control word with both the run bit and the immediate bit set. The channel works through a memory port that has one request outstanding at a time. Each request is held until the memory acknowledges it.

The words are grouped into blocks of a power-of-two size. Between blocks the channel idles for a pacing period, which is the interval value times a prescale divider. When the count runs out, the channel either stops or, in repeat mode, starts again. On a restart each side returns to its last written address only if its reload flag is set. A running total of moved words, a busy level and a one-cycle interrupt pulse are the channel's outputs.

Top module: `dma_word_channel`

## Requirements
- R1: After reset, busy, irq and memReq are 0 and xferCount is 0.
- R2: The register offsets on regAddr are 0 source, 1 destination, 2 total count, 3 pacing (interval in bits 15:0, prescale in bits 17:16), 4 fill word, 5 control. The control fields are bits 11:10 destination mode, 12 destination reload, 14:13 source mode, 15 source reload, 19:16 block code, 28 immediate, 29 repeat, 30 irq enable and 31 run. A control write with run=1 and immediate=1 while idle starts the channel. A control write with run=1 and immediate=0 leaves busy at 0 and issues no request.
- R3: In copy mode, each word is one read (memWe=0) at the source address followed by one write (memWe=1) at the destination address that carries the data just read.
- R4: Mode 0 adds 4 to the address after each word, mode 1 subtracts 4, and mode 2 holds the address. Source mode 3 is fill: no reads are issued, and every write carries the fill word. Destination mode 3 holds the address.
- R5: Block code n gives blocks of 2^n words. The last block is clamped to the words that remain. After each block that is not the last, the channel stays idle for interval×{1,4,16,64} extra cycles for prescale 0 to 3. Within a block, and for interval 0, no extra cycles are added.
- R6: When the total count is reached without repeat, busy falls, xferCount equals the total, and irq pulses for exactly one cycle if irq enable is set (otherwise not at all).
- R7: In repeat mode busy stays 1 across passes, and irq pulses once per pass. A side with its reload flag set restarts at its written address; a side without it keeps advancing. xferCount keeps accumulating.
- R8: A control write with run=0 while busy stops the channel once the word in flight completes. No further request is issued and no irq is raised.
- R9: A write to the source or destination register replaces the working address at once, and the last write wins. An address left unwritten carries over from the previous run.
- R10: Starting with a total count of 0 issues no request, leaves busy at 0, and pulses irq once if irq enable is set.
- R11: memReq is high only while busy. Address and write data stay stable from the start of a request until memAck.
- R12: A control write with run=1 while busy is ignored; the run goes on with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 32 | Register write data |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word address (multiple of 4) |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Request completion |
| xferCount | output | 28 | Words moved since the last start |
| busy | output | 1 | Channel running |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the idle gap before the first request of every block and compares it with the gap between words inside a block. A wrong prescale shift, a missing clamp on the last block, or a wait inserted at every word would each show up as a gap difference other than interval×divider. Repeat runs are checked word by word against the expected address sequence. A swapped or ignored reload flag would send the destination back to its start, or let the source run past the block. The abort is timed to land just after a write completes: a channel that ignored it would issue a fourth read, and one that raised the interrupt would count a pulse. Fill mode, a zero total, a start with the immediate bit clear and a control rewrite during a run each get their own runs. These catch stray reads, a stuck busy level, and settings changed in the middle of a transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_TOT  = 3'd2;
  localparam logic [2:0] REG_PACE = 3'd3;
  localparam logic [2:0] REG_FILL = 3'd4;
  localparam logic [2:0] REG_CTRL = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_RD, ST_WR, ST_WAIT
  } stateT;

  // control -> datapath
  typedef struct packed {
    logic startLoad;
    logic readDone;
    logic wordDone;
    logic blockReload;
    logic runReload;
    logic loadWait;
    logic decWait;
    logic wrPhase;
  } strobeT;

  // datapath -> control
  typedef struct packed {
    logic totalZero;
    logic remOne;
    logic blkOne;
    logic waitNone;
    logic waitOne;
    logic fillMode;
    logic repeatOn;
    logic irqOn;
  } statusT;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int XFER_W = 28,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              busy,
  input  logic              memReq,
  input  logic              memAck,
  input  strobeT            stb,
  output statusT            st,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [XFER_W-1:0] xferCount
);

  localparam int WAIT_W = IVL_W + 6;

  logic [ADDR_W-1:0] srcBase, srcWork, dstBase, dstWork;
  logic [CNT_W-1:0]  total, remaining, blockLeft;
  logic [IVL_W-1:0]  ivl;
  logic [1:0]        ps, srcMode, dstMode;
  logic [DATA_W-1:0] fillReg, dataLatch;
  logic              srcReload, dstReload, repeatOn, irqOn;
  logic [3:0]        blkCode, blkCodeNow;
  logic [WAIT_W-1:0] waitCnt, waitLen;
  logic [XFER_W-1:0] xferReg;
  logic [CNT_W-1:0]  blkWords, remMinus1, startBlk, nextBlk;
  logic              cfgWrite;

  function automatic logic [CNT_W-1:0] minCnt(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a, input logic [1:0] m);
    case (m)
      2'd0:    return a + ADDR_W'(4);
      2'd1:    return a - ADDR_W'(4);
      default: return a;
    endcase
  endfunction

  assign cfgWrite   = regWe && (regAddr == REG_CTRL) && !busy;
  assign blkCodeNow = stb.startLoad ? regWdata[19:16] : blkCode;
  assign blkWords   = CNT_W'(1) << blkCodeNow;
  assign remMinus1  = remaining - CNT_W'(1);
  assign startBlk   = minCnt(blkWords, total);
  assign nextBlk    = minCnt(blkWords, remMinus1);
  assign waitLen    = WAIT_W'(ivl) << {ps, 1'b0};

  assign st.totalZero = (total == '0);
  assign st.remOne    = (remaining == CNT_W'(1));
  assign st.blkOne    = (blockLeft == CNT_W'(1));
  assign st.waitNone  = (waitLen == '0);
  assign st.waitOne   = (waitCnt == WAIT_W'(1));
  assign st.fillMode  = (srcMode == 2'd3);
  assign st.repeatOn  = repeatOn;
  assign st.irqOn     = irqOn;

  assign memAddr   = stb.wrPhase ? dstWork : srcWork;
  assign memWdata  = st.fillMode ? fillReg : dataLatch;
  assign xferCount = xferReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase <= '0; srcWork <= '0; dstBase <= '0; dstWork <= '0;
      total <= '0; remaining <= '0; blockLeft <= '0;
      ivl <= '0; ps <= '0; fillReg <= '0; dataLatch <= '0;
      srcMode <= '0; dstMode <= '0; srcReload <= 1'b0; dstReload <= 1'b0;
      repeatOn <= 1'b0; irqOn <= 1'b0; blkCode <= '0;
      waitCnt <= '0; xferReg <= '0;
    end else begin
      if (stb.readDone) begin
        dataLatch <= memRdata;
        srcWork   <= stepAddr(srcWork, srcMode);
      end
      if (stb.startLoad) begin
        remaining <= total;
        blockLeft <= startBlk;
        xferReg   <= '0;
      end
      if (stb.wordDone) begin
        dstWork   <= stepAddr(dstWork, dstMode);
        xferReg   <= xferReg + XFER_W'(1);
        remaining <= remMinus1;
        blockLeft <= blockLeft - CNT_W'(1);
        if (stb.blockReload) blockLeft <= nextBlk;
        if (stb.runReload) begin
          remaining <= total;
          blockLeft <= startBlk;
          if (srcReload) srcWork <= srcBase;
          if (dstReload) dstWork <= dstBase;
        end
      end
      if (stb.loadWait)     waitCnt <= waitLen;
      else if (stb.decWait) waitCnt <= waitCnt - WAIT_W'(1);
      // software writes take effect last so they win over engine updates
      if (regWe) begin
        case (regAddr)
          REG_SRC:  begin srcBase <= regWdata[ADDR_W-1:0]; srcWork <= regWdata[ADDR_W-1:0]; end
          REG_DST:  begin dstBase <= regWdata[ADDR_W-1:0]; dstWork <= regWdata[ADDR_W-1:0]; end
          REG_TOT:  total <= regWdata[CNT_W-1:0];
          REG_PACE: begin ivl <= regWdata[IVL_W-1:0]; ps <= regWdata[17:16]; end
          REG_FILL: fillReg <= regWdata;
          default: ;
        endcase
      end
      if (cfgWrite) begin
        dstMode   <= regWdata[11:10];
        dstReload <= regWdata[12];
        srcMode   <= regWdata[14:13];
        srcReload <= regWdata[15];
        blkCode   <= regWdata[19:16];
        repeatOn  <= regWdata[29];
        irqOn     <= regWdata[30];
      end
    end
  end

  // R11: address held while a request waits for its acknowledge
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !regWe) |=> $stable(memAddr));

  // R5: a block never spans more words than remain
  a_r5_block_fits: assert property (@(posedge clk) disable iff (!rstN)
    blockLeft <= remaining);

  // R6: the word count never underflows
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordDone |-> (remaining != '0));

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   ctlWrite,
  input  logic   wRun,
  input  logic   wIrq,
  input  logic   wImm,
  input  logic   memAck,
  input  statusT st,
  output strobeT stb,
  output logic   busy,
  output logic   irq,
  output logic   memReq,
  output logic   memWe
);

  stateT state;
  logic  abortPend;
  logic  startReq, abortReq, lastWord, blockEnd;

  assign startReq = ctlWrite && !busy && wRun && wImm;
  assign abortReq = ctlWrite && busy && !wRun;
  assign lastWord = st.remOne;
  assign blockEnd = lastWord ? st.repeatOn : st.blkOne;

  always_comb begin
    stb             = '0;
    stb.startLoad   = startReq && !st.totalZero;
    stb.readDone    = (state == ST_RD) && memAck;
    stb.wordDone    = (state == ST_WR) && memAck;
    stb.runReload   = stb.wordDone && lastWord && st.repeatOn && !abortPend;
    stb.blockReload = stb.wordDone && !lastWord && st.blkOne;
    stb.loadWait    = stb.wordDone && !abortPend && blockEnd && !st.waitNone;
    stb.decWait     = (state == ST_WAIT);
    stb.wrPhase     = (state == ST_WR);
  end

  assign memReq = (state == ST_RD) || (state == ST_WR);
  assign memWe  = (state == ST_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      irq       <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (abortReq) abortPend <= 1'b1;
      case (state)
        ST_IDLE: begin
          abortPend <= 1'b0;
          if (startReq) begin
            if (st.totalZero) irq <= wIrq;
            else begin
              busy  <= 1'b1;
              state <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          if (abortPend) begin
            state <= ST_IDLE; busy <= 1'b0;
          end else state <= st.fillMode ? ST_WR : ST_RD;
        end
        ST_RD: if (memAck) state <= ST_WR;
        ST_WR: begin
          if (memAck) begin
            if (abortPend) begin
              state <= ST_IDLE; busy <= 1'b0;
            end else if (lastWord && !st.repeatOn) begin
              irq <= st.irqOn; state <= ST_IDLE; busy <= 1'b0;
            end else begin
              if (lastWord) irq <= st.irqOn;
              if (blockEnd) state <= st.waitNone ? ST_NEXT : ST_WAIT;
              else          state <= ST_NEXT;
            end
          end
        end
        ST_WAIT: begin
          if (abortPend) begin
            state <= ST_IDLE; busy <= 1'b0;
          end else if (st.waitOne) state <= ST_NEXT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: requests only while running
  a_r11_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R4: fill mode never reads
  a_r4_fill_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD) |-> !st.fillMode);

  // R8: no request once the channel has stopped
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !memReq);

endmodule

// File: rtl/dma_word_channel.sv
module dma_word_channel
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int XFER_W = 28,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [XFER_W-1:0] xferCount,
  output logic              busy,
  output logic              irq
);

  strobeT stb;
  statusT st;
  logic   ctlWrite;

  assign ctlWrite = regWe && (regAddr == REG_CTRL);

  dma_control u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite),
    .wRun(regWdata[31]), .wIrq(regWdata[30]), .wImm(regWdata[28]),
    .memAck(memAck), .st(st), .stb(stb), .busy(busy), .irq(irq),
    .memReq(memReq), .memWe(memWe)
  );

  dma_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .XFER_W(XFER_W), .IVL_W(IVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .memReq(memReq), .memAck(memAck), .stb(stb), .st(st),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .xferCount(xferCount)
  );

endmodule

// File: tb/dma_word_channel_tb.sv
`timescale 1ns/1ps
module dma_word_channel_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic [27:0] xferCount;
  logic        busy, irq;

  always #2.5 clk = ~clk;

  dma_word_channel u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .xferCount(xferCount), .busy(busy), .irq(irq)
  );

  int nChecks = 0, nErr = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory responder and logger
  int          nLog = 0, irqCount = 0, holdViol = 0, waitN = 0;
  bit          inReq = 0;
  logic [31:0] heldAddr;
  logic        logWe   [512];
  logic [31:0] logAddr [512];
  logic [31:0] logData [512];
  int          logReq  [512];
  int          logAck  [512];
  int          reqCyc  = 0;

  function automatic logic [31:0] initVal(input logic [31:0] addr);
    return 32'h1000_0000 + {24'd0, addr[9:2]} * 32'h0000_0101;
  endfunction

  always @(negedge clk) begin
    if (irq) irqCount++;
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (!inReq) begin
        inReq = 1; reqCyc = cyc; waitN = 0; heldAddr = memAddr;
      end else if (memAddr != heldAddr) holdViol++;
      if (waitN >= (nLog % 3)) begin
        memAck = 1'b1; inReq = 0;
        if (!memWe) memRdata = initVal(memAddr);
        if (nLog < 512) begin
          logWe[nLog] = memWe; logAddr[nLog] = memAddr;
          logData[nLog] = memWe ? memWdata : memRdata;
          logReq[nLog] = reqCyc; logAck[nLog] = cyc;
          nLog++;
        end
      end else waitN++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); #1;
    regWe = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int sm, input bit srl, input int dm, input bit drl,
                                      input int blk, input bit rep, input bit ie, input bit run, input bit imm);
    logic [31:0] v = '0;
    v[11:10] = dm[1:0]; v[12] = drl; v[14:13] = sm[1:0]; v[15] = srl;
    v[19:16] = blk[3:0]; v[28] = imm; v[29] = rep; v[30] = ie; v[31] = run;
    return v;
  endfunction

  int base = 0, irq0 = 0, g0 = 0;

  task automatic startJob(input logic [31:0] s, d, tot, pace, fill, c);
    base = nLog; irq0 = irqCount;
    wr(0, s); wr(1, d); wr(2, tot); wr(3, pace); wr(4, fill); wr(5, c);
  endtask

  task automatic waitIdle(input string tag);
    int t = 0;
    repeat (2) @(negedge clk);
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(!busy, tag, {31'd0, busy}, 0);
  endtask

  function automatic int gapAt(input int k);
    return logReq[base + 2*k] - logAck[base + 2*k - 1];
  endfunction

  initial begin
    #(100000 * 5);
    nErr++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !irq && !memReq, "R1 reset outputs", {busy, irq, memReq}, 0);
    chk(xferCount == 0, "R1 reset count", xferCount, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // T1: copy, increment both, blocks of 2, pace 3 at /4
    startJob(32'h00, 32'h80, 5, 32'h0001_0003, 0, ctl(0,0,0,0,1,0,1,1,1));
    waitIdle("R6 busy drop");
    chk(nLog - base == 10, "R3 access count", nLog - base, 10);
    for (int k = 0; k < 5; k++) begin
      chk(!logWe[base+2*k] && logAddr[base+2*k] == 4*k, "R3 read addr", logAddr[base+2*k], 4*k);
      chk(logWe[base+2*k+1] && logAddr[base+2*k+1] == 32'h80 + 4*k, "R4 write addr inc", logAddr[base+2*k+1], 32'h80 + 4*k);
      chk(logData[base+2*k+1] == initVal(4*k), "R3 write data", logData[base+2*k+1], initVal(4*k));
    end
    g0 = gapAt(1);
    chk(gapAt(3) == g0, "R5 intra-block gap", gapAt(3), g0);
    chk(gapAt(2) == g0 + 12, "R5 block wait /4", gapAt(2), g0 + 12);
    chk(gapAt(4) == g0 + 12, "R5 last block clamp wait", gapAt(4), g0 + 12);
    chk(xferCount == 5, "R6 xferCount", xferCount, 5);
    chk(irqCount - irq0 == 1, "R6 irq pulse", irqCount - irq0, 1);

    // T2: decrement source, fixed destination, block clamped to total
    startJob(32'h40, 32'h90, 3, 32'h0000_0007, 0, ctl(1,0,2,0,3,0,0,1,1));
    waitIdle("R6 busy drop");
    for (int k = 0; k < 3; k++) begin
      chk(logAddr[base+2*k] == 32'h40 - 4*k, "R4 src dec", logAddr[base+2*k], 32'h40 - 4*k);
      chk(logAddr[base+2*k+1] == 32'h90, "R4 dst fixed", logAddr[base+2*k+1], 32'h90);
      if (k > 0) chk(gapAt(k) == g0, "R5 clamped single block", gapAt(k), g0);
    end
    chk(irqCount == irq0, "R6 no irq when disabled", irqCount - irq0, 0);

    // T3: fill mode, destination decrement
    startJob(32'h00, 32'hFC, 4, 0, 32'hC0DE_F00D, ctl(3,0,1,0,0,0,1,1,1));
    waitIdle("R6 busy drop");
    chk(nLog - base == 4, "R4 fill no reads", nLog - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk(logWe[base+k] && logAddr[base+k] == 32'hFC - 4*k, "R4 fill dst dec", logAddr[base+k], 32'hFC - 4*k);
      chk(logData[base+k] == 32'hC0DE_F00D, "R4 fill data", logData[base+k], 32'hC0DE_F00D);
    end

    // T4: prescale sweep plus interval zero
    for (int p = 0; p < 5; p++) begin
      int ps = (p < 4) ? p : 0;
      int iv = (p < 4) ? 2 : 0;
      startJob(32'h00, 32'h80, 2, (ps << 16) | iv, 0, ctl(0,0,0,0,0,0,0,1,1));
      waitIdle("R6 busy drop");
      chk(gapAt(1) == g0 + (iv << (2*ps)), "R5 prescale wait", gapAt(1), g0 + (iv << (2*ps)));
    end

    // T5: repeat, source reloads, destination continues
    startJob(32'h10, 32'hC0, 2, 0, 0, ctl(0,1,0,0,1,1,1,1,1));
    begin
      int t = 0;
      while (irqCount - irq0 < 3 && t < 2000) begin @(negedge clk); t++; end
    end
    chk(busy, "R7 busy across passes", {31'd0, busy}, 1);
    wr(5, 0);
    waitIdle("R8 abort repeat");
    begin
      int nw = 0;
      for (int i = base; i < nLog; i++) if (logWe[i]) begin
        chk(logAddr[i] == 32'hC0 + 4*nw, "R7 dst continues", logAddr[i], 32'hC0 + 4*nw);
        chk(logData[i] == initVal(32'h10 + 4*(nw % 2)), "R7 src reload data", logData[i], initVal(32'h10 + 4*(nw % 2)));
        nw++;
      end
      chk(nw >= 6, "R7 three passes", nw, 6);
      chk(xferCount == nw, "R7 count accumulates", xferCount, nw);
    end

    // T6: abort right after the third write
    startJob(32'h00, 32'h80, 10, 0, 0, ctl(0,0,0,0,2,0,1,1,1));
    begin
      int t = 0, nw = 0;
      while (nw < 3 && t < 2000) begin
        @(negedge clk); #1; t++;
        nw = 0;
        for (int i = base; i < nLog; i++) if (logWe[i]) nw++;
      end
      regWe = 1'b1; regAddr = 3'd5; regWdata = 0;
      @(negedge clk); #1; regWe = 1'b0;
    end
    waitIdle("R8 abort stop");
    repeat (10) @(negedge clk);
    chk(nLog - base == 6, "R8 no access after abort", nLog - base, 6);
    chk(xferCount == 3, "R8 count at abort", xferCount, 3);
    chk(irqCount == irq0, "R8 no irq on abort", irqCount - irq0, 0);

    // T7: run without immediate
    startJob(32'h00, 32'h80, 4, 0, 0, ctl(0,0,0,0,0,0,1,1,0));
    repeat (20) @(negedge clk);
    chk(!busy && nLog == base, "R2 no immediate no start", nLog - base, 0);

    // T8: zero total
    startJob(32'h00, 32'h80, 0, 0, 0, ctl(0,0,0,0,0,0,1,1,1));
    repeat (10) @(negedge clk);
    chk(!busy && nLog == base, "R10 zero total no access", nLog - base, 0);
    chk(irqCount - irq0 == 1, "R10 zero total irq", irqCount - irq0, 1);

    // T9: control rewrite while running is ignored
    startJob(32'h00, 32'h80, 6, 32'h0003_0005, 0, ctl(0,0,0,0,0,0,1,1,1));
    repeat (10) @(negedge clk);
    wr(5, ctl(3,0,2,0,0,1,0,1,1));
    waitIdle("R12 run ends");
    chk(nLog - base == 12, "R12 original config", nLog - base, 12);
    chk(irqCount - irq0 == 1, "R12 irq kept", irqCount - irq0, 1);
    chk(gapAt(1) == g0 + 320, "R12 pacing kept", gapAt(1), g0 + 320);

    // T10: latest source write wins, destination carries over (0x80 + 6*4)
    base = nLog;
    wr(0, 32'h20); wr(0, 32'h30); wr(2, 1);
    wr(5, ctl(0,0,0,0,0,0,0,1,1));
    waitIdle("R9 run ends");
    chk(logAddr[base] == 32'h30, "R9 src latest write", logAddr[base], 32'h30);
    chk(logAddr[base+1] == 32'h98, "R9 dst carries over", logAddr[base+1], 32'h98);

    chk(holdViol == 0, "R11 address stable", holdViol, 0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule